// File: doc/BRIEF.md
# Prioritised Fixed-Vector Interrupt Controller

This block sits beside a small processor core. It decides which interrupt request to take next and tells the core where to jump. Five sources feed it. The first is a non-maskable trap. Three restart inputs are gated both by a global enable and by their own mask bit. The last is a general request whose target comes from an opcode that external logic drives onto the data bus. The trap and the three restart inputs each have a fixed target address. When one of them wins, the block pulses `redirect_o` for one cycle and presents the address on `target_o`.

The global enable is set by an enable pulse from the core, one pulse for each executed enable instruction. Taking any maskable source clears the enable again. When the general request wins, the block raises an acknowledge strobe for a fixed number of cycles. In the last of those cycles it samples the data bus. If the byte is a restart opcode, the block redirects to eight times the restart number.

An active-low reset clears all of the block's state. It also holds a reset output, which asks the core to load address zero, both while reset is asserted and for a stretch of cycles after it is released.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, and for RST_HOLD clock edges after it rises, `rst_out_o` and `redirect_o` are high, `target_o` is 0x0000 and `inta_o` is low. Reset also clears the enable, sets all three mask bits (masked) and empties both edge latches.
- R2: A rising edge on `trap_i` is latched. It is taken whatever the enable and mask state, and the target is 0x0024. Holding `trap_i` high produces only one redirect. Taking the trap leaves the enable unchanged.
- R3: A rising edge on `rst75_i` is latched and stays pending until it is taken, even while it is masked. It is taken when the enable is set and mask bit 2 is clear, and the target is 0x003C.
- R4: `rst65_i` and `rst55_i` are level-sensitive. They are gated by the enable and by mask bits 1 and 0 respectively. Their targets are 0x0034 and 0x002C.
- R5: When several sources are eligible, the order of preference is: trap, then 7.5, then 6.5, then 5.5, then the general request.
- R6: `intr_i` is taken only while the enable is set. Taking it raises `inta_o` for exactly INTA_LEN cycles, starting on the edge that takes it.
- R7: On the edge that ends the acknowledge, `data_i` is decoded. A byte of the form 11nnn111 gives a one-cycle redirect to nnn×8 (0xE7 gives 0x0020). Any other byte gives no redirect.
- R8: Taking 7.5, 6.5, 5.5 or the general request clears the enable. `ei_i` sets the enable. If `ei_i` arrives on the same edge as a take, the take wins.
- R9: A pulse on `set_mask_i` loads `mask_i` into the mask. Bit 2 is for 7.5, bit 1 for 6.5 and bit 0 for 5.5, and a 1 blocks the input.
- R10: No source is taken while `inta_o` or `rst_out_o` is high. Requests that are still pending are served once both are low.
- R11: Outside reset, `redirect_o` is a single-cycle pulse for each source taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Non-maskable trap request (edge) |
| rst75_i | input | 1 | Restart 7.5 request (edge, latched) |
| rst65_i | input | 1 | Restart 6.5 request (level) |
| rst55_i | input | 1 | Restart 5.5 request (level) |
| intr_i | input | 1 | General request (level) |
| ei_i | input | 1 | Enable-instruction executed pulse |
| set_mask_i | input | 1 | Load strobe for the mask |
| mask_i | input | 3 | New mask value (1 = blocked) |
| data_i | input | 8 | Data bus, sampled at the end of the acknowledge |
| inta_o | output | 1 | Acknowledge strobe for the general request |
| redirect_o | output | 1 | Core must load `target_o` into its program counter |
| target_o | output | AW | Jump target |
| rst_out_o | output | 1 | Reset output for the core and for peripherals |

## Verification
Directed sequences hold each source high in turn against different enable and mask settings. A level held after it has been taken shows whether the enable clear is working. A masked 7.5 edge followed by an unmask shows whether the edge latch holds a request that is not served at once. Raising every request together and then releasing the enable one take at a time shows the preference order. Acknowledges are run with a restart opcode and with a non-restart byte, and a trap arrives during an acknowledge. A long constrained-random run with a reset in the middle compares every cycle against a bench model, which exposes collisions between enable pulses, mask writes and takes.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int unsigned NSRC     = 5;
   localparam int unsigned IDX_INTR = 0;
   localparam int unsigned IDX_R55  = 1;
   localparam int unsigned IDX_R65  = 2;
   localparam int unsigned IDX_R75  = 3;
   localparam int unsigned IDX_TRAP = 4;

   // Fixed-vector sources sit at restart slot n, offset by four bytes.
   function automatic logic [7:0] fixed_vector(input int unsigned idx);
      int unsigned slot;
      slot = (idx == IDX_TRAP) ? 4 : idx + 4;
      return 8'(slot * 8 + 4);
   endfunction
endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         pend_o <= (pend_o & ~clr_i) | (lvl_i & ~prev_q);
      end
   end

   // R3
   hold_until_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && !clr_i) |=> pend_o);
   // R2
   rise_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_i) |=> pend_o);
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);
   if (N < 2) begin : g_n_chk
      $error("irqv_arbiter: N must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_pri
      if (i == N - 1) begin : g_top
         assign grant_o[i] = en_i & req_i[i];
      end else begin : g_low
         assign grant_o[i] = en_i & req_i[i] & ~(|req_i[N-1:i+1]);
      end
   end

   // R5
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   // R5
   no_lost_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && (|req_i)) |-> (|grant_o));
endmodule

// File: rtl/irqv_ack_seq.sv
module irqv_ack_seq #(
   parameter int unsigned LEN = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [7:0] opc_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       ok_o,
   output logic [7:0] vec_o
);
   localparam int unsigned CW = $clog2(LEN + 1);

   if (LEN < 1 || LEN > 255) begin : g_len_chk
      $error("irqv_ack_seq: LEN must lie in 1..255");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= CW'(LEN);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));
   assign ok_o   = (opc_i[7:6] == 2'b11) && (opc_i[2:0] == 3'b111);
   assign vec_o  = {2'b00, opc_i[5:3], 3'b000};

   // R10
   no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
   // R6
   ack_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   // R6
   ack_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqv_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned INTA_LEN  = 3,
   parameter int unsigned RST_HOLD  = 2,
   parameter bit          TRAP_EDGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trap_i,
   input  logic          rst75_i,
   input  logic          rst65_i,
   input  logic          rst55_i,
   input  logic          intr_i,
   input  logic          ei_i,
   input  logic          set_mask_i,
   input  logic [2:0]    mask_i,
   input  logic [7:0]    data_i,
   output logic          inta_o,
   output logic          redirect_o,
   output logic [AW-1:0] target_o,
   output logic          rst_out_o
);
   localparam int unsigned RCW = $clog2(RST_HOLD + 1);

   if (AW < 8) begin : g_aw_chk
      $error("irq_vector_ctrl: AW must be at least 8");
   end
   if (RST_HOLD < 1) begin : g_hold_chk
      $error("irq_vector_ctrl: RST_HOLD must be at least 1");
   end

   logic [RCW-1:0]  rst_cnt_q;
   logic            ie_q;
   logic [2:0]      mask_q;
   logic            trap_pend, r75_pend;
   logic [NSRC-1:0] req, grant;
   logic            arb_en, take_fixed, take_mask;
   logic [7:0]      fix_vec;
   logic            ack_done, ack_ok;
   logic [7:0]      ack_vec;
   logic            redir_q;

   // reset stretch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rst_cnt_q <= RCW'(RST_HOLD);
      else if (rst_cnt_q != '0)  rst_cnt_q <= rst_cnt_q - RCW'(1);
   end
   assign rst_out_o = (rst_cnt_q != '0);

   // trap capture variant
   if (TRAP_EDGE) begin : g_trap_edge
      irqv_edge_latch u_trap (
         .clk(clk), .rst_n(rst_n), .lvl_i(trap_i),
         .clr_i(grant[IDX_TRAP]), .pend_o(trap_pend));
   end else begin : g_trap_level
      assign trap_pend = trap_i;
   end

   irqv_edge_latch u_r75 (
      .clk(clk), .rst_n(rst_n), .lvl_i(rst75_i),
      .clr_i(grant[IDX_R75]), .pend_o(r75_pend));

   always_comb begin
      req           = '0;
      req[IDX_TRAP] = trap_pend;
      req[IDX_R75]  = r75_pend & ie_q & ~mask_q[2];
      req[IDX_R65]  = rst65_i  & ie_q & ~mask_q[1];
      req[IDX_R55]  = rst55_i  & ie_q & ~mask_q[0];
      req[IDX_INTR] = intr_i   & ie_q;
   end

   assign arb_en = ~rst_out_o & ~inta_o;

   irqv_arbiter #(.N(NSRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .en_i(arb_en), .req_i(req), .grant_o(grant));

   assign take_fixed = |grant[NSRC-1:1];
   assign take_mask  = |grant[IDX_R75:0];

   always_comb begin
      fix_vec = '0;
      for (int unsigned i = 1; i < NSRC; i++)
         if (grant[i]) fix_vec = fixed_vector(i);
   end

   irqv_ack_seq #(.LEN(INTA_LEN)) u_ack (
      .clk(clk), .rst_n(rst_n), .start_i(grant[IDX_INTR]), .opc_i(data_i),
      .busy_o(inta_o), .done_o(ack_done), .ok_o(ack_ok), .vec_o(ack_vec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q     <= 1'b0;
         mask_q   <= 3'b111;
         redir_q  <= 1'b0;
         target_o <= '0;
      end else begin
         if (take_mask)   ie_q <= 1'b0;
         else if (ei_i)   ie_q <= 1'b1;
         if (set_mask_i)  mask_q <= mask_i;
         redir_q <= 1'b0;
         if (take_fixed) begin
            redir_q  <= 1'b1;
            target_o <= AW'(fix_vec);
         end else if (ack_done && ack_ok) begin
            redir_q  <= 1'b1;
            target_o <= AW'(ack_vec);
         end
      end
   end

   assign redirect_o = redir_q | rst_out_o;

   // R1
   reset_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out_o |-> (redirect_o && target_o == '0 && !inta_o));
   // R8
   take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_mask |=> !ie_q);
   // R2
   trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_pend && arb_en) |-> grant[IDX_TRAP]);
   // R10
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inta_o || rst_out_o) |-> (grant == '0));
   // R11
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !rst_out_o) |=> (!redirect_o || $past(take_fixed) || $past(ack_done)));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
   localparam int CLK_P    = 10;
   localparam int INTA_LEN = 3;
   localparam int RST_HOLD = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, intr_i = 0, ei_i = 0, set_mask_i = 0;
   logic [2:0]  mask_i = 0;
   logic [7:0]  data_i = 0;
   logic        inta_o, redirect_o, rst_out_o;
   logic [15:0] target_o;

   int total = 0, bad = 0, cyc = 0;

   irq_vector_ctrl #(.AW(16), .INTA_LEN(INTA_LEN), .RST_HOLD(RST_HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rst75_i(rst75_i), .rst65_i(rst65_i),
      .rst55_i(rst55_i), .intr_i(intr_i), .ei_i(ei_i), .set_mask_i(set_mask_i),
      .mask_i(mask_i), .data_i(data_i), .inta_o(inta_o), .redirect_o(redirect_o),
      .target_o(target_o), .rst_out_o(rst_out_o));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%0h exp=%0h at cycle %0d", tag, got, exp, cyc);
      end
   endtask

   // ---- bench reference functions ----
   function automatic logic [15:0] ref_vec(input int src);
      case (src)
         4: return 16'h0024;
         3: return 16'h003C;
         2: return 16'h0034;
         default: return 16'h002C;
      endcase
   endfunction
   function automatic bit ref_op_ok(input logic [7:0] b);
      return (b[7] && b[6] && b[2] && b[1] && b[0]);
   endfunction
   function automatic logic [15:0] ref_op_vec(input logic [7:0] b);
      return 16'(int'(b[5:3]) * 8);
   endfunction
   function automatic int ref_pick(input logic [4:0] r);
      for (int i = 4; i >= 0; i--) if (r[i]) return i;
      return -1;
   endfunction

   // ---- cycle model ----
   bit m_ie = 0, m_pt = 0, m_p75 = 0, m_prt = 0, m_pr75 = 0, m_redir = 0;
   bit [2:0] m_mask = 3'b111;
   logic [15:0] m_tgt = 0;
   int m_ack = 0, m_rst = RST_HOLD, m_g = -1;
   bit m_busy = 0, m_tm = 0;
   logic [4:0] m_req;
   string m_tag = "R1";
   bit model_on = 1'b1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ie = 0; m_mask = 3'b111; m_pt = 0; m_p75 = 0; m_prt = 0; m_pr75 = 0;
         m_ack = 0; m_redir = 0; m_tgt = 0; m_rst = RST_HOLD; m_tag = "R1";
      end else begin
         m_busy = (m_rst != 0) || (m_ack != 0);
         m_req  = {m_pt, m_p75 & m_ie & ~m_mask[2], rst65_i & m_ie & ~m_mask[1],
                   rst55_i & m_ie & ~m_mask[0], intr_i & m_ie};
         m_g    = m_busy ? -1 : ref_pick(m_req);
         m_tm   = (m_g >= 0) && (m_g <= 3);
         m_redir = 0;
         if (m_ack != 0) begin
            if (m_ack == 1 && ref_op_ok(data_i)) begin
               m_redir = 1; m_tgt = ref_op_vec(data_i); m_tag = "R7";
            end
            m_ack--;
         end
         if (m_g >= 1) begin
            m_redir = 1; m_tgt = ref_vec(m_g);
            m_tag = (m_g == 4) ? "R2" : (m_g == 3) ? "R3" : "R4";
         end
         if (m_g == 0) m_ack = INTA_LEN;
         if (m_tm) m_ie = 0; else if (ei_i) m_ie = 1;
         if (set_mask_i) m_mask = mask_i;
         m_pt  = (m_pt  && m_g != 4) || (trap_i  && !m_prt);
         m_p75 = (m_p75 && m_g != 3) || (rst75_i && !m_pr75);
         m_prt = trap_i; m_pr75 = rst75_i;
         if (m_rst != 0) m_rst--;
      end
      #(CLK_P/4);
      if (model_on) begin
         chk({"R11 redirect/", m_tag}, redirect_o, m_redir || (m_rst != 0));
         chk({"R5 target/", m_tag}, target_o, m_tgt);
         chk("R6 inta", inta_o, m_ack != 0);
         chk("R1 rst_out", rst_out_o, m_rst != 0);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog: got=%0d exp<=150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---- directed helpers ----
   task automatic wait_redirect(input string tag, input logic [15:0] exp);
      bit seen = 0;
      for (int i = 0; i < 12; i++) begin
         if (redirect_o && !rst_out_o) begin seen = 1; break; end
         @(negedge clk);
      end
      chk(tag, seen, 1);
      if (seen) chk(tag, target_o, exp);
   endtask
   task automatic expect_quiet(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(tag, redirect_o, 0);
      end
   endtask
   task automatic pulse_ei();
      @(negedge clk); ei_i = 1;
      @(negedge clk); ei_i = 0;
   endtask
   task automatic load_mask(input logic [2:0] m);
      @(negedge clk); set_mask_i = 1; mask_i = m;
      @(negedge clk); set_mask_i = 0;
   endtask
   task automatic run_ack(input string tag, output int n);
      n = 0;
      for (int i = 0; i < 10 && !inta_o; i++) @(negedge clk);
      intr_i = 0;
      while (inta_o && n < 20) begin n++; @(negedge clk); end
      chk(tag, n, INTA_LEN);
   endtask

   initial begin
      int n;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk("R1 rst_out in reset", rst_out_o, 1);
      chk("R1 redirect in reset", redirect_o, 1);
      chk("R1 target in reset", target_o, 0);
      chk("R1 inta in reset", inta_o, 0);
      @(negedge clk); rst_n = 1;
      repeat (RST_HOLD) @(negedge clk);
      chk("R1 rst_out released", rst_out_o, 0);

      // R2 trap ignores enable/mask, edge only
      @(negedge clk); trap_i = 1;
      wait_redirect("R2 trap vector", 16'h0024);
      @(negedge clk); chk("R11 one pulse", redirect_o, 0);
      expect_quiet("R2 held trap no repeat", 4);
      trap_i = 0;

      // R4 5.5 level, R8 enable cleared by take
      load_mask(3'b000);
      pulse_ei();
      @(negedge clk); rst55_i = 1;
      wait_redirect("R4 5.5 vector", 16'h002C);
      expect_quiet("R8 enable cleared", 6);
      rst55_i = 0;

      // R9 mask blocks 6.5, 5.5 still open
      load_mask(3'b010);
      pulse_ei();
      @(negedge clk); rst65_i = 1;
      expect_quiet("R9 6.5 masked", 6);
      rst55_i = 1;
      wait_redirect("R4 5.5 under mask 010", 16'h002C);
      @(negedge clk); rst55_i = 0; rst65_i = 0;

      // R5 priority
      load_mask(3'b000);
      @(negedge clk); rst75_i = 1;
      @(negedge clk); rst75_i = 0; rst65_i = 1; rst55_i = 1; intr_i = 1;
      pulse_ei();
      wait_redirect("R5 7.5 first", 16'h003C);
      pulse_ei();
      wait_redirect("R5 6.5 second", 16'h0034);
      @(negedge clk); rst65_i = 0;
      pulse_ei();
      wait_redirect("R5 5.5 third", 16'h002C);
      @(negedge clk); rst55_i = 0; intr_i = 0;

      // R6 intr needs enable; R7 bad opcode rejected
      @(negedge clk); intr_i = 1; data_i = 8'h3E;
      expect_quiet("R6 intr without enable", 5);
      chk("R6 no inta without enable", inta_o, 0);
      pulse_ei();
      run_ack("R6 inta length", n);
      chk("R7 non-restart opcode ignored", redirect_o, 0);

      // R7 restart opcode, R10 trap waits for acknowledge
      @(negedge clk); data_i = 8'hE7; intr_i = 1;
      pulse_ei();
      for (int i = 0; i < 10 && !inta_o; i++) @(negedge clk);
      intr_i = 0; trap_i = 1;
      n = 0;
      while (inta_o && n < 20) begin
         chk("R10 no redirect during inta", redirect_o, 0);
         n++; @(negedge clk);
      end
      chk("R6 inta length 2", n, INTA_LEN);
      chk("R7 restart redirect", redirect_o, 1);
      chk("R7 restart target", target_o, 16'h0020);
      @(negedge clk); trap_i = 0;
      chk("R10 trap after inta", redirect_o, 1);
      chk("R10 trap target", target_o, 16'h0024);

      // R3 7.5 edge latched while masked
      load_mask(3'b100);
      pulse_ei();
      @(negedge clk); rst75_i = 1;
      @(negedge clk); rst75_i = 0;
      expect_quiet("R3 7.5 masked", 5);
      load_mask(3'b000);
      wait_redirect("R3 latched 7.5 served", 16'h003C);

      // constrained random against the model, reset in the middle
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         if (c == 2000) rst_n = 0;
         if (c == 2003) rst_n = 1;
         if ($urandom % 32 == 0) trap_i  = ~trap_i;
         if ($urandom % 8  == 0) rst75_i = ~rst75_i;
         if ($urandom % 6  == 0) rst65_i = ~rst65_i;
         if ($urandom % 6  == 0) rst55_i = ~rst55_i;
         if ($urandom % 6  == 0) intr_i  = ~intr_i;
         ei_i       = ($urandom % 5 == 0);
         set_mask_i = ($urandom % 12 == 0);
         mask_i     = 3'($urandom);
         data_i     = ($urandom % 2 == 0) ? {2'b11, 3'($urandom), 3'b111} : 8'($urandom);
      end
      @(negedge clk);
      model_on = 1'b0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule